// File: doc/BRIEF.md
# Skewed-Operand Pipelined Ripple-Carry ALU

This block is a 32-bit arithmetic/logic unit whose carry chain is cut into four 8-bit ripple-carry slices, with a register on the carry path between each pair of neighbouring slices. Slice 0 works on the newest operation, slice 1 on the one issued a cycle earlier, and so on. Each slice therefore runs a different operation in the same cycle. Because a carry never crosses more than eight bit positions per clock, the critical path is one slice deep rather than one word deep.

To make the staggered slices see consistent data, the operand bits for slice k are held back k cycles on the way in. The opcode follows the operation down the slices through its own chain of registers. Each slice's result is then held for the remaining stages, so that all 32 result bits and the final carry leave together. A valid tag travels alongside. A caller may issue one operation every clock and collects the aligned answer exactly four clocks later. The block has no stall and no back-pressure.

Reset is synchronous and active high. It clears every carry, skew, deskew, opcode and valid register, which flushes any operations still in flight.

Top module: `skewed_alu`

## Requirements
- R1: Opcode 0 (add) yields `{out_carry, out_result}` equal to the 33-bit sum `in_a + in_b`.
- R2: Opcode 1 (subtract) yields `{out_carry, out_result}` equal to `in_a + ~in_b + 1` taken to 33 bits, so `out_carry` is 1 exactly when no borrow occurs (`in_a >= in_b`).
- R3: Opcodes 2, 3 and 4 (AND, OR, XOR) yield the bitwise result with `out_carry` 0. Carries produced by earlier operations still in the lower slices have no effect on them.
- R4: Opcodes 5, 6 and 7 are unused and yield `out_result` 0 and `out_carry` 0.
- R5: `out_valid` equals `in_valid` from exactly four clock edges earlier, and the result of an operation appears in the same cycle as its tag.
- R6: A new operation may issue on every clock. Back-to-back operations with different opcodes each produce their own correct result, with no bubbles and no interference.
- R7: A carry generated in slice 0 ripples through every higher slice, so 0xFFFFFFFF + 1 gives result 0 with `out_carry` 1.
- R8: At a clock edge with `rst` high, all pipeline state is cleared. On the following cycle `out_valid`, `out_result` and `out_carry` are 0, and operations issued before the reset never emerge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the issued operation as real |
| in_op | input | 3 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 xor) |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Tag of the operation leaving the pipeline |
| out_result | output | 32 | Aligned 32-bit result |
| out_carry | output | 1 | Carry out of the top slice |

## Verification
The assertions check several behaviours on every cycle: the valid tag emerges exactly four edges after issue, the arithmetic and logic results match their operands from four edges back, unused opcodes give zero, and a reset edge leaves all outputs zero. Other behaviours can only be shown by the bench's scenarios. These are the full-width carry ripple from all-ones plus one, logic operations that directly follow carry-heavy additions, long back-to-back runs of mixed opcodes, and a reset that lands while operations are still in flight.

// File: rtl/skewed_alu_pkg.sv
`timescale 1ns/1ps
package skewed_alu_pkg;

    localparam int unsigned OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } alu_op_e;

endpackage

// File: rtl/slice_delay.sv
`timescale 1ns/1ps
// Fixed-depth register line, depth 0 is a plain wire.
module slice_delay #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_regs
            logic [WIDTH-1:0] stage_q [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < int'(DEPTH); i++) stage_q[i] <= '0;
                end else begin
                    stage_q[0] <= din;
                    for (int i = 1; i < int'(DEPTH); i++) stage_q[i] <= stage_q[i-1];
                end
            end
            assign dout = stage_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/alu_slice.sv
`timescale 1ns/1ps
// One ripple-carry slice, purely combinational.
module alu_slice
    import skewed_alu_pkg::*;
#(
    parameter int unsigned SLICE_W = 8
) (
    input  logic [OP_W-1:0]    op,
    input  logic [SLICE_W-1:0] a,
    input  logic [SLICE_W-1:0] b,
    input  logic               cin,
    output logic [SLICE_W-1:0] res,
    output logic               cout
);
    logic [SLICE_W:0] sum_ext;

    always_comb begin
        sum_ext = '0;
        res     = '0;
        cout    = 1'b0;
        case (op)
            OP_ADD: begin
                sum_ext = {1'b0, a} + {1'b0, b} + {{SLICE_W{1'b0}}, cin};
                res     = sum_ext[SLICE_W-1:0];
                cout    = sum_ext[SLICE_W];
            end
            OP_SUB: begin
                sum_ext = {1'b0, a} + {1'b0, ~b} + {{SLICE_W{1'b0}}, cin};
                res     = sum_ext[SLICE_W-1:0];
                cout    = sum_ext[SLICE_W];
            end
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/skewed_alu.sv
`timescale 1ns/1ps
module skewed_alu
    import skewed_alu_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned SLICE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_carry
);
    localparam int unsigned NSLICE = DATA_W / SLICE_W;

    // opcode travelling down the slices: op_q[k] feeds slice k (k >= 1)
    logic [OP_W-1:0]   op_q    [NSLICE];
    logic [NSLICE-1:0] carry_c;
    logic [NSLICE-1:0] carry_q;
    logic [SLICE_W-1:0] res_c  [NSLICE];
    logic [SLICE_W-1:0] res_q  [NSLICE];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < int'(NSLICE); k++) begin
                op_q[k]  <= '0;
                res_q[k] <= '0;
            end
            carry_q <= '0;
        end else begin
            op_q[0] <= '0;
            for (int k = 1; k < int'(NSLICE); k++)
                op_q[k] <= (k == 1) ? in_op : op_q[k-1];
            for (int k = 0; k < int'(NSLICE); k++)
                res_q[k] <= res_c[k];
            carry_q <= carry_c;
        end
    end

    generate
        for (genvar k = 0; k < NSLICE; k++) begin : g_slice
            logic [SLICE_W-1:0] a_skew;
            logic [SLICE_W-1:0] b_skew;
            logic [OP_W-1:0]    op_here;
            logic               cin_here;

            slice_delay #(.WIDTH(SLICE_W), .DEPTH(k)) u_skew_a (
                .clk(clk), .rst(rst),
                .din(in_a[k*SLICE_W +: SLICE_W]), .dout(a_skew)
            );
            slice_delay #(.WIDTH(SLICE_W), .DEPTH(k)) u_skew_b (
                .clk(clk), .rst(rst),
                .din(in_b[k*SLICE_W +: SLICE_W]), .dout(b_skew)
            );

            if (k == 0) begin : g_first
                assign op_here  = in_op;
                assign cin_here = (in_op == OP_SUB);
            end else begin : g_upper
                assign op_here  = op_q[k];
                assign cin_here = carry_q[k-1];
            end

            alu_slice #(.SLICE_W(SLICE_W)) u_slice (
                .op(op_here), .a(a_skew), .b(b_skew), .cin(cin_here),
                .res(res_c[k]), .cout(carry_c[k])
            );

            slice_delay #(.WIDTH(SLICE_W), .DEPTH(NSLICE-1-k)) u_deskew (
                .clk(clk), .rst(rst),
                .din(res_q[k]), .dout(out_result[k*SLICE_W +: SLICE_W])
            );
        end
    endgenerate

    slice_delay #(.WIDTH(1), .DEPTH(NSLICE)) u_valid_line (
        .clk(clk), .rst(rst), .din(in_valid), .dout(out_valid)
    );

    assign out_carry = carry_q[NSLICE-1];

endmodule

// File: rtl/skewed_alu_chk.sv
`timescale 1ns/1ps
module skewed_alu_chk #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned SLICE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [2:0]        in_op,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] in_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_carry
);
    localparam int unsigned LAT = DATA_W / SLICE_W;

    logic              hv [LAT];
    logic [2:0]        hop[LAT];
    logic [DATA_W-1:0] ha [LAT];
    logic [DATA_W-1:0] hb [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(LAT); i++) begin
                hv[i] <= 1'b0; hop[i] <= '0; ha[i] <= '0; hb[i] <= '0;
            end
        end else begin
            hv[0] <= in_valid; hop[0] <= in_op; ha[0] <= in_a; hb[0] <= in_b;
            for (int i = 1; i < int'(LAT); i++) begin
                hv[i] <= hv[i-1]; hop[i] <= hop[i-1]; ha[i] <= ha[i-1]; hb[i] <= hb[i-1];
            end
        end
    end

    logic              t_v;
    logic [2:0]        t_op;
    logic [DATA_W-1:0] t_a, t_b;
    assign t_v  = hv[LAT-1];
    assign t_op = hop[LAT-1];
    assign t_a  = ha[LAT-1];
    assign t_b  = hb[LAT-1];

    // R5
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == t_v);

    // R1
    add_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (t_v && t_op == 3'd0) |-> {out_carry, out_result} == ({1'b0, t_a} + {1'b0, t_b}));

    // R2
    sub_diff_chk: assert property (@(posedge clk) disable iff (rst)
        (t_v && t_op == 3'd1) |-> {out_carry, out_result} == ({1'b0, t_a} + {1'b0, ~t_b} + 1));

    // R3
    logic_op_chk: assert property (@(posedge clk) disable iff (rst)
        (t_v && t_op >= 3'd2 && t_op <= 3'd4) |->
            (!out_carry && out_result == ((t_op == 3'd2) ? (t_a & t_b) :
                                          (t_op == 3'd3) ? (t_a | t_b) : (t_a ^ t_b))));

    // R4
    unused_op_chk: assert property (@(posedge clk) disable iff (rst)
        (t_v && t_op > 3'd4) |-> (!out_carry && out_result == '0));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_carry && out_result == '0));

endmodule

bind skewed_alu skewed_alu_chk #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_chk (.*);

// File: tb/skewed_alu_test.sv
`timescale 1ns/1ps
module skewed_alu_test;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [31:0] in_a = '0, in_b = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_carry;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    logic        rv   [8];
    logic [32:0] rexp [8];
    string       rtag [8];

    always #4 clk = ~clk;   // 125 MHz

    skewed_alu uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_result(out_result), .out_carry(out_carry)
    );

    function automatic logic [32:0] model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            3'd0: return {1'b0, a} + {1'b0, b};
            3'd1: return {1'b0, a} + {1'b0, ~b} + 33'd1;
            3'd2: return {1'b0, a & b};
            3'd3: return {1'b0, a | b};
            3'd4: return {1'b0, a ^ b};
            default: return 33'd0;
        endcase
    endfunction

    function automatic string op_tag(input logic [2:0] op);
        if (op == 3'd0) return "R1";
        if (op == 3'd1) return "R2";
        if (op <= 3'd4) return "R3";
        return "R4";
    endfunction

    task automatic report(input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic check_slot();
        int idx = (cyc + 8 - LAT) % 8;
        report("R5 valid", 64'(out_valid), 64'(rv[idx]));
        if (rv[idx])
            report(rtag[idx], 64'({out_carry, out_result}), 64'(rexp[idx]));
    endtask

    task automatic step(input logic v, input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input string tag);
        @(negedge clk);
        check_slot();
        rst = 1'b0; in_valid = v; in_op = op; in_a = a; in_b = b;
        rv[cyc % 8] = v; rexp[cyc % 8] = model(op, a, b); rtag[cyc % 8] = tag;
        cyc++;
    endtask

    task automatic do_reset(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0) begin
                // R8: outputs cleared on the cycle after a reset edge
                report("R8 valid", 64'(out_valid), 64'd0);
                report("R8 result", 64'({out_carry, out_result}), 64'd0);
            end
            rst = 1'b1; in_valid = 1'b1; in_op = 3'd0; in_a = '1; in_b = '1;
            for (int j = 0; j < 8; j++) rv[j] = 1'b0;
            cyc++;
        end
    endtask

    initial begin
        #1600000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int j = 0; j < 8; j++) begin rv[j] = 1'b0; rexp[j] = '0; rtag[j] = ""; end
        do_reset(3);

        // R7: full ripple from slice 0 to the top
        step(1, 3'd0, 32'hFFFF_FFFF, 32'h0000_0001, "R7");
        step(1, 3'd0, 32'h00FF_FFFF, 32'h0000_0001, "R7");
        step(1, 3'd1, 32'd5, 32'd7, "R2");
        step(1, 3'd1, 32'd7, 32'd5, "R2");
        step(1, 3'd1, 32'h1234_5678, 32'h1234_5678, "R2");
        // R3: logic right after carry-heavy adds
        step(1, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");
        step(1, 3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
        step(1, 3'd3, 32'hF0F0_0000, 32'h0F0F_00FF, "R3");
        step(1, 3'd4, 32'hFFFF_FFFF, 32'hAAAA_5555, "R3");
        step(1, 3'd0, 32'h8000_0000, 32'h8000_0000, "R1");
        step(1, 3'd6, 32'hFFFF_FFFF, 32'h0000_0001, "R4");
        step(1, 3'd5, 32'h1234_5678, 32'h9ABC_DEF0, "R4");
        step(1, 3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
        step(0, 3'd0, 32'hFFFF_FFFF, 32'h1, "R5");
        step(1, 3'd0, 32'd100, 32'd23, "R1");
        step(0, 3'd1, 32'd0, 32'd0, "R5");
        step(1, 3'd1, 32'd0, 32'd1, "R2");

        // R6: back-to-back mixed operations
        for (int i = 0; i < 300; i++) begin
            logic [2:0]  op = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(5, 7)) : 3'($urandom_range(0, 4));
            logic [31:0] a  = ($urandom_range(0, 5) == 0) ? 32'hFFFF_FFFF : $urandom;
            logic [31:0] b  = ($urandom_range(0, 5) == 0) ? 32'h0000_0001 : $urandom;
            step(($urandom_range(0, 7) != 0), op, a, b, {"R6 ", op_tag(op)});
        end

        // R8: reset while operations are in flight
        step(1, 3'd0, 32'hFFFF_FFFF, 32'h1, "R8");
        step(1, 3'd4, 32'h1, 32'h2, "R8");
        step(1, 3'd1, 32'h3, 32'h9, "R8");
        do_reset(2);
        for (int i = 0; i < 6; i++) step(0, 3'd0, 32'd0, 32'd0, "R8");
        step(1, 3'd0, 32'hFFFF_FFFF, 32'h0000_0001, "R7");
        step(1, 3'd3, 32'h0, 32'hC0DE_0000, "R3");
        for (int i = 0; i < 6; i++) step(0, 3'd0, 32'd0, 32'd0, "R5");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule